// File: doc/BRIEF.md
# Multi-Input Edge Wake-Up Unit

This unit watches sixteen asynchronous input lines and turns selected transitions on them into interrupt requests. Each line is synchronised to the local clock. Its own polarity bit picks whether a rising or a falling transition counts. Every counted transition latches a per-line pending flag. Software programs the unit through a flat register port, and the pending flags are cleared by writing ones.

Four interrupt outputs collect the pending lines. A two-bit field per line names the output that the line feeds, and a per-line enable gates whether its pending flag reaches that output. The OR of the four outputs forms a wake signal. A power controller uses it to leave halt, idle or power-save states. Any output can also serve as an ordinary maskable edge interrupt.

Top module: `edge_wake_unit`

## Requirements
- R1: After reset, the enable, polarity, pending and both route registers read as zero, and all interrupt outputs and the wake output are low.
- R2: Each input passes through two synchroniser flops and a history flop. A transition applied before clock edge A shows in the pending flag after edge A+2 and not earlier. For the first three clock edges after reset, no transition is detected, so a level held through reset creates no event.
- R3: In the polarity register, a 1 in bit c makes channel c detect low-to-high transitions, and a 0 makes it detect high-to-low transitions. A transition of the other direction leaves the pending flag unchanged.
- R4: Writing the polarity register while an input is steady does not set that channel's pending flag.
- R5: Pending flags are set whether or not the channel is enabled. Bit c of the enable register gates only the contribution of channel c to the interrupt and wake outputs, so enabling a channel that is already pending raises its output on the cycle after the write.
- R6: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. A write can never set a pending bit.
- R7: When a detected transition and a clearing write hit the same channel on the same clock edge, the pending flag ends up set.
- R8: Channel c has a two-bit route field at bits [2*(c%8)+1 : 2*(c%8)] of route word c/8. Interrupt output k is high exactly when some channel routed to k is both pending and enabled.
- R9: The wake output equals the OR of the four interrupt outputs. It is combinational from the registered state.
- R10: Register addresses are 0 enable, 1 polarity, 2 pending, 3 route word 0 (channels 0-7) and 4 route word 1 (channels 8-15). Reads are combinational and return zero at unused addresses. Enable, polarity and route words read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | 16 | Asynchronous channel inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 4 | Interrupt outputs |
| wake | output | 1 | Wake request, OR of irq |

## Verification
The hardest case to reach from the ports is a transition that becomes a detected event on the very clock edge at which software writes a one to clear the same pending bit. The bench takes this from the known three-edge latency. It changes the input, waits two falling clock edges, and then presents the clearing write so that both reach the register on the same rising edge. A second hard case is a polarity rewrite while the input is steady high, since a detector that compares polarity-adjusted levels would produce an event there. Random traffic then mixes transitions, clears and route changes, and checks them against a cycle model.

// File: rtl/ewu_pkg.sv
package ewu_pkg;
  localparam int ADDR_W    = 3;
  localparam int A_ENABLE  = 0;
  localparam int A_POLAR   = 1;
  localparam int A_PEND    = 2;
  localparam int A_ROUTE0  = 3;
endpackage

// File: rtl/ewu_sync.sv
module ewu_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/ewu_edge.sv
module ewu_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] hist_q;
  logic [1:0]   warm_q, warm_d;
  logic         armed;

  // Warm-up count: detection starts once the history flop holds a real sample
  assign armed = (warm_q == 2'd3);

  always_comb begin
    warm_d = armed ? warm_q : warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      warm_q <= '0;
    end else begin
      hist_q <= sync_in;
      warm_q <= warm_d;
    end
  end

  // Compare raw synchronised samples; polarity only picks the direction
  genvar c;
  generate
    for (c = 0; c < W; c++) begin : g_det
      logic up, down;
      assign up     = sync_in[c] & ~hist_q[c];
      assign down   = ~sync_in[c] & hist_q[c];
      assign hit[c] = armed & (rise_sel[c] ? up : down);
    end
  endgenerate
endmodule

// File: rtl/ewu_regs.sv
module ewu_regs
  import ewu_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_OUT = 4,
  localparam int SEL_W  = $clog2(NUM_OUT),
  localparam int RWORDS = SEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NUM_CH-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [NUM_CH-1:0]       rd_data,
  input  logic [NUM_CH-1:0]       set_vec,
  input  logic [NUM_CH-1:0]       clr_vec,
  output logic [NUM_CH-1:0]       en_q,
  output logic [NUM_CH-1:0]       pol_q,
  output logic [NUM_CH-1:0]       pend_q,
  output logic [NUM_CH*SEL_W-1:0] sel_flat
);
  logic              en_ce, pol_ce;
  logic [NUM_CH-1:0] pend_d;
  logic [NUM_CH-1:0] route_q [RWORDS];

  assign en_ce  = wr_en && (wr_addr == ADDR_W'(A_ENABLE));
  assign pol_ce = wr_en && (wr_addr == ADDR_W'(A_POLAR));

  // Set has priority over clear
  always_comb begin
    pend_d = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      pend_q <= '0;
    end else begin
      if (en_ce)  en_q  <= wr_data;
      if (pol_ce) pol_q <= wr_data;
      pend_q <= pend_d;
    end
  end

  genvar w;
  generate
    for (w = 0; w < RWORDS; w++) begin : g_route
      logic rt_ce;
      assign rt_ce = wr_en && (wr_addr == ADDR_W'(A_ROUTE0 + w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     route_q[w] <= '0;
        else if (rt_ce) route_q[w] <= wr_data;
      end
      assign sel_flat[w*NUM_CH +: NUM_CH] = route_q[w];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_ENABLE): rd_data = en_q;
      ADDR_W'(A_POLAR):  rd_data = pol_q;
      ADDR_W'(A_PEND):   rd_data = pend_q;
      default: begin
        for (int i = 0; i < RWORDS; i++) begin
          if (rd_addr == ADDR_W'(A_ROUTE0 + i)) rd_data = route_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/ewu_route.sv
module ewu_route #(
  parameter int NUM_CH  = 16,
  parameter int NUM_OUT = 4,
  localparam int SEL_W  = $clog2(NUM_OUT)
) (
  input  logic [NUM_CH-1:0]       pend,
  input  logic [NUM_CH-1:0]       en,
  input  logic [NUM_CH*SEL_W-1:0] sel_flat,
  output logic [NUM_OUT-1:0]      irq
);
  logic [NUM_CH-1:0] live;
  assign live = pend & en;

  genvar k;
  generate
    for (k = 0; k < NUM_OUT; k++) begin : g_out
      logic [NUM_CH-1:0] member;
      for (genvar c = 0; c < NUM_CH; c++) begin : g_mem
        assign member[c] = (sel_flat[c*SEL_W +: SEL_W] == SEL_W'(k));
      end
      assign irq[k] = |(live & member);
    end
  endgenerate
endmodule

// File: rtl/edge_wake_unit.sv
module edge_wake_unit
  import ewu_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_OUT = 4,
  localparam int SEL_W  = $clog2(NUM_OUT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   chan_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_CH-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [NUM_CH-1:0]   rd_data,
  output logic [NUM_OUT-1:0]  irq,
  output logic                wake
);
  logic [NUM_CH-1:0]       sync_v, edge_hit, clr_vec, en_q, pol_q, pend_q;
  logic [NUM_CH*SEL_W-1:0] sel_flat;

  assign clr_vec = (wr_en && (wr_addr == ADDR_W'(A_PEND))) ? wr_data : '0;

  ewu_sync #(.W(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(chan_in), .sync_out(sync_v)
  );

  ewu_edge #(.W(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_v), .rise_sel(pol_q), .hit(edge_hit)
  );

  ewu_regs #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .set_vec(edge_hit), .clr_vec(clr_vec),
    .en_q(en_q), .pol_q(pol_q), .pend_q(pend_q), .sel_flat(sel_flat)
  );

  ewu_route #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) u_route (
    .pend(pend_q), .en(en_q), .sel_flat(sel_flat), .irq(irq)
  );

  assign wake = |irq;
endmodule

// File: rtl/ewu_checker.sv
module ewu_checker #(
  parameter int NUM_CH  = 16,
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_CH-1:0]  pend,
  input logic [NUM_CH-1:0]  hit,
  input logic [NUM_CH-1:0]  clr,
  input logic [NUM_CH-1:0]  en,
  input logic [NUM_OUT-1:0] irq,
  input logic               wake
);
  // R7: a detected edge always leaves its flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(hit)) == $past(hit)));

  // R6: cleared bits without a simultaneous edge end up low
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr & ~hit)) == '0));

  // R6: bits neither cleared nor hit keep their value
  a_r6_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend ^ $past(pend)) & ~$past(clr | hit)) == '0));

  // R9: wake follows the interrupt outputs
  a_r9_wake_or: assert property (@(posedge clk) disable iff (!rst_n)
    wake == (|irq));

  // R5: an output can only be high if some channel is pending and enabled
  a_r5_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> (|(pend & en)));
endmodule

bind edge_wake_unit ewu_checker #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_q), .hit(edge_hit), .clr(clr_vec),
  .en(en_q), .irq(irq), .wake(wake)
);

// File: tb/edge_wake_unit_tb.sv
module edge_wake_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] din;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic [3:0]  irq;
  logic        wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  edge_wake_unit u_dut (
    .clk(clk), .rst_n(rst_n), .chan_in(din), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake)
  );

  // Cycle model built from the requirements
  logic [15:0] m_s1, m_s2, m_prev, m_en, m_pol, m_pend, m_rt0, m_rt1, hitv, clrv;
  logic [2:0]  m_warm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_warm <= '0;
      m_en <= '0; m_pol <= '0; m_pend <= '0; m_rt0 <= '0; m_rt1 <= '0;
    end else begin
      hitv = m_warm[2] ? ((m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev)) : 16'h0;
      clrv = (wr_en && wr_addr == 3'd2) ? wr_data : 16'h0;
      m_pend <= (m_pend & ~clrv) | hitv;
      m_s1 <= din; m_s2 <= m_s1; m_prev <= m_s2;
      m_warm <= {m_warm[1:0], 1'b1};
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_en  <= wr_data;
          3'd1: m_pol <= wr_data;
          3'd3: m_rt0 <= wr_data;
          3'd4: m_rt1 <= wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [3:0] exp_irq();
    logic [3:0] r = '0;
    for (int c = 0; c < 16; c++) begin
      logic [1:0] s = (c < 8) ? m_rt0[2*c +: 2] : m_rt1[2*(c-8) +: 2];
      if (m_pend[c] && m_en[c]) r[s] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_en;
      3'd1: return m_pol;
      3'd2: return m_pend;
      3'd3: return m_rt0;
      3'd4: return m_rt1;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; din = 16'h0001; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(6);
    // R1 reset state
    for (int a = 0; a < 5; a++) rdchk("R1 reset reg", 3'(a), 16'h0);
    chk("R1 reset irq", irq, 4'h0);
    chk("R1 reset wake", wake, 1'b0);
    // R2: level held through reset gives no event
    rdchk("R2 warm-up", 3'd2, 16'h0);
    // R4: polarity rewrite with ch0 steady high
    wr(3'd1, 16'h0001);
    step(4);
    rdchk("R4 polarity change", 3'd2, 16'h0);
    // R2 latency on ch1 rising
    wr(3'd1, 16'h0003);
    din[1] = 1'b1;
    step(2);
    rdchk("R2 not before third edge", 3'd2, 16'h0);
    step(1);
    rdchk("R2 third edge", 3'd2, 16'h0002);
    // R3: ch2 falling mode ignores rise, catches fall
    din[2] = 1'b1; step(4);
    rdchk("R3 opposite edge", 3'd2, 16'h0002);
    din[2] = 1'b0; step(4);
    rdchk("R3 selected edge", 3'd2, 16'h0006);
    // R5 enable gating
    chk("R5 disabled irq", irq, 4'h0);
    chk("R5 disabled wake", wake, 1'b0);
    wr(3'd0, 16'h0004);
    chk("R5 enabled irq", irq, 4'b0001);
    chk("R9 wake follows", wake, 1'b1);
    // R8 routing
    wr(3'd3, 16'h0030);
    chk("R8 ch2 to out3", irq, 4'b1000);
    wr(3'd0, 16'h0006);
    chk("R8 ch1 to out0", irq, 4'b1001);
    wr(3'd4, 16'h0020);
    wr(3'd1, 16'h0403);
    din[10] = 1'b1; step(3);
    wr(3'd0, 16'h0406);
    chk("R8 ch10 to out2", irq, 4'b1101);
    rdchk("R10 route0 readback", 3'd3, 16'h0030);
    rdchk("R10 route1 readback", 3'd4, 16'h0020);
    rdchk("R10 unused addr", 3'd6, 16'h0);
    // R6 write-one-to-clear
    wr(3'd2, 16'h0000);
    rdchk("R6 zero write", 3'd2, 16'h0406);
    wr(3'd2, 16'h8000);
    rdchk("R6 no set by write", 3'd2, 16'h0406);
    wr(3'd2, 16'h0002);
    rdchk("R6 clear one", 3'd2, 16'h0404);
    chk("R6 irq after clear", irq, 4'b1100);
    wr(3'd2, 16'h0404);
    chk("R9 wake low", wake, 1'b0);
    chk("R6 irq all clear", irq, 4'h0);
    // R7 set wins over clear on ch3
    wr(3'd1, 16'h040B);
    din[3] = 1'b1; step(3);
    rdchk("R7 setup pending", 3'd2, 16'h0008);
    din[3] = 1'b0; step(4);
    din[3] = 1'b1;
    step(2);
    wr(3'd2, 16'h0008);
    rdchk("R7 set wins", 3'd2, 16'h0008);
    wr(3'd2, 16'h0008);
    rdchk("R7 control clear", 3'd2, 16'h0);

    // Random phase against the model (R2 R3 R5 R6 R8 R9 R10)
    for (int it = 0; it < 4000; it++) begin
      rd_addr = 3'($urandom % 8);
      #1;
      chk("R10 random read", rd_data, exp_rd(rd_addr));
      chk("R8 random irq", irq, exp_irq());
      chk("R9 random wake", wake, |exp_irq());
      if ($urandom % 3 == 0) din = din ^ (16'h1 << ($urandom % 16));
      if ($urandom % 6 == 0) begin
        wr_en = 1'b1;
        case ($urandom % 5)
          0: wr_addr = 3'd0;
          1: wr_addr = 3'd1;
          2: wr_addr = 3'd2;
          3: wr_addr = 3'd3;
          default: wr_addr = 3'd4;
        endcase
        wr_data = 16'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule